// File: doc/BRIEF.md
# Burst column address sequencer

This block produces the column address for every data beat of one read or write burst in a double-data-rate SDRAM-style memory. A small configuration register holds the burst length (2, 4 or 8 beats) and the burst type (sequential or interleaved). It is loaded only on a mode-register-write strobe. After a start request, the block emits one column address per clock, with a valid flag and a flag that marks the final beat.

The beat order never leaves the aligned block whose size equals the burst length. The low start bits give the first offset inside that block. In sequential mode the offset counts up and wraps at the block edge. In interleaved mode the offset is the start offset XOR the beat index. The column bits above the block stay fixed for the whole burst. A length code outside the three legal values is flagged, and no burst starts while that flag is set.

Top module: `burst_col_seq`

## Requirements
- R1: Length codes on `cfg_len_code` are 3'b001 = 2 beats, 3'b010 = 4 beats and 3'b011 = 8 beats. An accepted burst asserts `col_valid` for exactly that many consecutive cycles.
- R2: With `cfg_interleave` = 0 (sequential), the in-block offset of beat i is (s + i) mod BL, where s is the start column's low log2(BL) bits.
- R3: With `cfg_interleave` = 1 (interleaved), the in-block offset of beat i is s XOR i.
- R4: Every beat's column bits above the in-block offset equal those of `start_col`. The upper bits of `col_out` do not change within a burst.
- R5: A configuration write with any other length code (3'b000 or 3'b100 to 3'b111) sets `cfg_bad`. While `cfg_bad` is 1, `start` is ignored. A later write with a legal code clears `cfg_bad`.
- R6: Length and type change only on a `cfg_wr` cycle. A burst keeps the settings that were in the register when it was accepted. A `cfg_wr` during a burst, or in the same cycle as the accepted `start`, affects only later bursts.
- R7: `start` is ignored while a burst is in progress, including the cycle of its final beat. The cycle after the final beat is idle.
- R8: After reset the block is idle, `cfg_bad` is 0, and the configuration is 2 beats, sequential.
- R9: The first beat appears on the cycle after the accepted `start`. `col_last` is 1 on the final beat only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Mode-register-write strobe; loads length and type |
| cfg_len_code | input | 3 | Burst length code |
| cfg_interleave | input | 1 | Burst type: 0 sequential, 1 interleaved |
| start | input | 1 | Start request for one burst |
| start_col | input | COL_W | Start column address |
| col_out | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | A beat is present on `col_out` |
| col_last | output | 1 | Current beat is the last of the burst |
| cfg_bad | output | 1 | Last configuration write carried a reserved length code |

## Verification
Two pairs of events can fall in the same clock cycle. The first pair is a configuration write and a start request. The bench raises both on one edge, then judges the burst against the old length and type, and the next burst against the new ones. The second pair is a start request and a burst's final beat. The bench drives `start` with a different column during the middle beats and during the final beat. It expects the running burst's addresses to be unchanged and the following cycle to be idle. All other bursts are compared beat by beat with a reference model. That model covers every start offset, length and type, plus seeded random columns.

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 12,
  parameter int OFF_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [2:0]       cfg_len_code,
  input  logic             cfg_interleave,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  output logic [COL_W-1:0] col_out,
  output logic             col_valid,
  output logic             col_last,
  output logic             cfg_bad
);

  localparam logic [2:0] DEF_CODE = 3'd1;

  logic [2:0]       len_q;
  logic             il_q;
  logic             act;
  logic             il_b;
  logic [COL_W-1:0] base;
  logic [OFF_W-1:0] off0, idx, mask, beat_off;

  wire              code_ok  = (cfg_len_code != 3'd0) && (int'(cfg_len_code) <= OFF_W);
  wire              go       = start && !act && !cfg_bad;
  wire [OFF_W-1:0]  cur_mask = OFF_W'((32'd1 << len_q) - 32'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q   <= DEF_CODE;
      il_q    <= 1'b0;
      cfg_bad <= 1'b0;
    end else if (cfg_wr) begin
      len_q   <= cfg_len_code;
      il_q    <= cfg_interleave;
      cfg_bad <= !code_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act  <= 1'b0;
      il_b <= 1'b0;
      base <= '0;
      off0 <= '0;
      idx  <= '0;
      mask <= '0;
    end else if (go) begin
      act  <= 1'b1;
      il_b <= il_q;
      base <= start_col;
      mask <= cur_mask;
      off0 <= start_col[OFF_W-1:0] & cur_mask;
      idx  <= '0;
    end else if (act) begin
      if (idx == mask) act <= 1'b0;
      else             idx <= idx + 1'b1;
    end
  end

  assign beat_off  = il_b ? (off0 ^ idx) : ((off0 + idx) & mask);
  assign col_out   = {base[COL_W-1:OFF_W], (base[OFF_W-1:0] & ~mask) | beat_off};
  assign col_valid = act;
  assign col_last  = act && (idx == mask);

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 12,
  parameter int OFF_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [COL_W-1:0] col_out,
  input logic             col_valid,
  input logic             col_last,
  input logic             cfg_bad
);

  assert_burst_runs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !col_last |=> col_valid);

  assert_upper_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !col_last |=> col_out[COL_W-1:OFF_W] == $past(col_out[COL_W-1:OFF_W]));

  assert_bad_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bad && !col_valid |=> !col_valid);

  assert_idle_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |=> !col_valid);

  assert_first_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_valid) |-> $past(start));

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .col_out(col_out),
  .col_valid(col_valid), .col_last(col_last), .cfg_bad(cfg_bad)
);

// File: tb/tb_burst_col_seq.sv
module tb_burst_col_seq;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W = 12;

  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0, cfg_interleave = 0, start = 0;
  logic [2:0] cfg_len_code = 3'd1;
  logic [COL_W-1:0] start_col = '0;
  logic [COL_W-1:0] col_out;
  logic col_valid, col_last, cfg_bad;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_seq #(.COL_W(COL_W), .OFF_W(3)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_len_code(cfg_len_code),
    .cfg_interleave(cfg_interleave), .start(start), .start_col(start_col),
    .col_out(col_out), .col_valid(col_valid), .col_last(col_last), .cfg_bad(cfg_bad));

  function automatic logic [COL_W-1:0] exp_col(logic [COL_W-1:0] c, int bl, bit il, int i);
    int m = bl - 1;
    int s = int'(c) & m;
    int o = il ? (s ^ i) : ((s + i) & m);
    return logic'(1'b0) ? '0 : COL_W'((int'(c) & ~m) | o);
  endfunction

  function automatic logic [2:0] code_of(int bl);
    return bl == 2 ? 3'd1 : bl == 4 ? 3'd2 : 3'd3;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(logic [2:0] code, bit il);
    @(negedge clk);
    cfg_wr = 1; cfg_len_code = code; cfg_interleave = il;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic burst(logic [COL_W-1:0] c, int bl, bit il, string tag);
    @(negedge clk);
    start = 1; start_col = c;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < bl; i++) begin
      chk(col_valid === 1'b1, {tag, " R1 valid"}, col_valid, 1);
      chk(col_out === exp_col(c, bl, il, i), il ? {tag, " R3 order"} : {tag, " R2 order"},
          col_out, exp_col(c, bl, il, i));
      chk(col_last === (i == bl - 1), {tag, " R9 last"}, col_last, i == bl - 1);
      @(negedge clk);
    end
    chk(col_valid === 1'b0, {tag, " R1 end"}, col_valid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [COL_W-1:0] c;
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(col_valid === 1'b0, "R8 idle", col_valid, 0);
    chk(cfg_bad === 1'b0, "R8 cfg_bad", cfg_bad, 0);
    burst(12'h0A7, 2, 0, "R8 default");

    for (int t = 0; t < 2; t++)
      for (int b = 1; b <= 3; b++) begin
        cfg(3'(b), t[0]);
        for (int s = 0; s < 8; s++) burst(COL_W'(12'h530 | s), 1 << b, t[0], "sweep");
      end

    cfg(3'd3, 1);
    burst(12'h003, 8, 1, "R3 len8 start3");
    cfg(3'd2, 1);
    burst(12'h001, 4, 1, "R3 len4 start1");
    cfg(3'd3, 0);
    burst(12'hFFD, 8, 0, "R2 len8 start5");

    // R7: start while busy, including the final beat
    cfg(3'd2, 0);
    c = 12'h6B6;
    @(negedge clk); start = 1; start_col = c;
    @(negedge clk); start_col = 12'h111;
    for (int i = 0; i < 4; i++) begin
      chk(col_out === exp_col(c, 4, 0, i), "R7 busy ignore", col_out, exp_col(c, 4, 0, i));
      chk(col_last === (i == 3), "R7 last", col_last, i == 3);
      @(negedge clk);
    end
    start = 0;
    chk(col_valid === 1'b0, "R7 idle after last", col_valid, 0);

    // R5: reserved codes
    cfg(3'd0, 0);
    chk(cfg_bad === 1'b1, "R5 flag code0", cfg_bad, 1);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(col_valid === 1'b0, "R5 no start", col_valid, 0);
    cfg(3'd5, 1);
    chk(cfg_bad === 1'b1, "R5 flag code5", cfg_bad, 1);
    cfg(3'd2, 1);
    chk(cfg_bad === 1'b0, "R5 cleared", cfg_bad, 0);
    burst(12'h3C2, 4, 1, "R5 after clear");

    // R6: write during a burst
    cfg(3'd3, 0);
    c = 12'h246;
    @(negedge clk); start = 1; start_col = c;
    @(negedge clk); start = 0;
    for (int i = 0; i < 8; i++) begin
      if (i == 1) begin cfg_wr = 1; cfg_len_code = 3'd1; cfg_interleave = 1; end
      else cfg_wr = 0;
      chk(col_out === exp_col(c, 8, 0, i), "R6 mid-burst write", col_out, exp_col(c, 8, 0, i));
      @(negedge clk);
    end
    cfg_wr = 0;
    burst(12'h247, 2, 1, "R6 new cfg");

    // R6: write in the same cycle as start
    cfg(3'd2, 0);
    c = 12'h8E5;
    @(negedge clk); start = 1; start_col = c;
    cfg_wr = 1; cfg_len_code = 3'd3; cfg_interleave = 1;
    @(negedge clk); start = 0; cfg_wr = 0;
    for (int i = 0; i < 4; i++) begin
      chk(col_out === exp_col(c, 4, 0, i), "R6 same-cycle old cfg", col_out, exp_col(c, 4, 0, i));
      chk(col_last === (i == 3), "R6 same-cycle last", col_last, i == 3);
      @(negedge clk);
    end
    burst(12'h8E5, 8, 1, "R6 same-cycle new cfg");

    // random mix; R4 upper bits checked via exp_col
    for (int k = 0; k < 200; k++) begin
      int bl = 2 << ($urandom % 3);
      bit il = $urandom % 2;
      cfg(code_of(bl), il);
      burst(COL_W'($urandom), bl, il, "R4 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule